// File: doc/BRIEF.md
# VGA Planar Write Datapath

This block turns a single host byte write into a write to four-plane video memory, following the graphics-controller rules of a standard VGA adapter. Each memory word holds four 8-bit planes. Plane p occupies bits 8p+7 down to 8p. The block supports two kinds of write.

A byte-addressed write (chain-4 or odd/even) touches exactly one plane of one word. A planar write builds a full 32-bit word in four steps:

- the selected write mode forms a value and a bit mask;
- a raster logic function combines the value with the latch;
- the bit mask merges the result with the latch;
- the plane enables decide which planes are stored.

The host side supplies the byte address, the data, a write strobe and the current register fields. The latch comes from the read datapath. The memory side is a registered write port with one byte enable per plane. Every accepted write shows up on this port exactly one clock after the strobe.

Top module: `vga_planar_writer`

## Requirements
- R1: A write whose 17-bit address is 0x10000 or above produces no memory write. Address 0xFFFF is accepted.
- R2: With `chain4_en` set, the plane is `wr_addr[1:0]` and the word address is `wr_addr[15:2]`. The byte is written only when `plane_en` has that plane's bit set. `chain4_en` takes priority over `oddeven_en`.
- R3: With `oddeven_en` set and `chain4_en` clear, the plane is {`page_hi`, `wr_addr[0]`} and the word address is `wr_addr[15:1]`. The write is gated by that plane's bit of `plane_en`. In both byte modes the data byte appears in every lane of `mem_wdata`.
- R4: Write mode 0 (`wmode`=0) rotates the byte right by `rot_cnt` and copies it to all planes. Each plane p with `sr_enable[p]`=1 is replaced by 0xFF if `sr_value[p]`=1, or 0x00 otherwise. The bit mask is `bit_mask`.
- R5: Write mode 1 writes `latch` unchanged. The logic function and the bit mask have no effect, and only the plane enables apply.
- R6: Write mode 2 uses, for plane p, 0xFF if `wr_byte[p]`=1 and 0x00 otherwise. The bit mask is `bit_mask`.
- R7: Write mode 3 uses the expansion of `sr_value` as the value. The bit mask is `bit_mask` AND the rotated byte.
- R8: `lfun` chooses the logic function applied against the latch: 0 passes the value, 1 ANDs, 2 ORs, 3 XORs.
- R9: Outside mode 1, each plane's result is (value AND mask) OR (latch AND NOT mask), with the same 8-bit mask in every plane.
- R10: In planar modes `mem_be` equals `plane_en`. `mem_we` is high only when at least one byte enable is set. A disabled plane is never written.
- R11: The port is registered: an accepted write appears one cycle after `wr_en`. A cycle without `wr_en` gives `mem_we`=0. Reset clears the port to zero.
- R12: A rotate count of 0 leaves the byte unchanged. Rotation always stays within 8 bits; for example 0x01 rotated by 7 gives 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 17 | Host byte address within the aperture |
| wr_byte | input | 8 | Host write data |
| plane_en | input | 4 | Per-plane write enable |
| chain4_en | input | 1 | Chain-4 byte addressing |
| oddeven_en | input | 1 | Odd/even byte addressing |
| page_hi | input | 1 | High plane-pair select for odd/even |
| wmode | input | 2 | Write mode 0..3 |
| rot_cnt | input | 3 | Right-rotate count |
| lfun | input | 2 | Logic function against latch |
| sr_value | input | 4 | Per-plane set/reset value |
| sr_enable | input | 4 | Per-plane set/reset enable (mode 0) |
| bit_mask | input | 8 | Bit mask, copied to each plane |
| latch | input | 32 | Latched word from the read path |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write word, plane p in bits 8p+7:8p |
| mem_be | output | 4 | Per-plane byte enable |

## Verification
The block keeps no state besides the output register. A wrong internal choice (a mis-selected write mode, a swapped lane, a bad rotate or a wrong merge) therefore appears on `mem_wdata`, `mem_be` or `mem_addr` on the very clock after the strobe. The bench compares all of them at that point. Corner cases that could hide a fault are driven on purpose: rotate by 0 and by 7, an all-zero bit mask, masks that cover only part of the planes, the last in-window address and the first out-of-window address, and byte modes with the target plane disabled. Any of these shows up as a stray or missing write on the following cycle.

// File: rtl/vgaw_pkg.sv
package vgaw_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int ROT_W  = $clog2(LANE_W);
    localparam int LSEL_W = $clog2(LANES);

    typedef enum logic [1:0] {
        WM_ROTATE = 2'd0,
        WM_LATCH  = 2'd1,
        WM_EXPAND = 2'd2,
        WM_MASKED = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        LF_PASS = 2'd0,
        LF_AND  = 2'd1,
        LF_OR   = 2'd2,
        LF_XOR  = 2'd3
    } lfun_e;

    // one bit per plane blown up to a full lane of ones or zeros
    function automatic logic [WORD_W-1:0] spread_bits(input logic [LANES-1:0] sel);
        logic [WORD_W-1:0] w;
        for (int p = 0; p < LANES; p++) begin
            w[p*LANE_W +: LANE_W] = {LANE_W{sel[p]}};
        end
        return w;
    endfunction

    function automatic logic [LANE_W-1:0] rot_right(input logic [LANE_W-1:0] v,
                                                     input logic [ROT_W-1:0]  n);
        logic [2*LANE_W-1:0] t;
        t = {v, v} >> n;
        return t[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/vgaw_mode_stage.sv
// Write-mode stage: forms the per-plane value and the 8-bit bit mask.
module vgaw_mode_stage
    import vgaw_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [ROT_W-1:0]  rot,
    input  logic [LANE_W-1:0] data,
    input  logic [LANES-1:0]  srv,
    input  logic [LANES-1:0]  sre,
    input  logic [LANE_W-1:0] gmask,
    input  logic [WORD_W-1:0] latch,
    output logic [WORD_W-1:0] value,
    output logic [LANE_W-1:0] mask8,
    output logic              bypass
);
    wmode_e            wm;
    logic [LANE_W-1:0] rot_byte;
    logic [WORD_W-1:0] sr_word;
    logic [WORD_W-1:0] exp_word;
    logic [WORD_W-1:0] m0_word;

    assign wm       = wmode_e'(mode);
    assign rot_byte = rot_right(data, rot);
    assign sr_word  = spread_bits(srv);
    assign exp_word = spread_bits(data[LANES-1:0]);

    // mode 0: rotated byte per plane, replaced by set/reset where enabled
    for (genvar p = 0; p < LANES; p++) begin : g_setreset
        assign m0_word[p*LANE_W +: LANE_W] =
            sre[p] ? sr_word[p*LANE_W +: LANE_W] : rot_byte;
    end

    always_comb begin
        bypass = 1'b0;
        mask8  = gmask;
        value  = m0_word;
        case (wm)
            WM_ROTATE: value = m0_word;
            WM_LATCH: begin
                value  = latch;
                mask8  = '1;
                bypass = 1'b1;
            end
            WM_EXPAND: value = exp_word;
            WM_MASKED: begin
                value = sr_word;
                mask8 = gmask & rot_byte;
            end
            default: value = m0_word;
        endcase
    end
endmodule

// File: rtl/vgaw_rop_stage.sv
// Logic-function and bit-mask merge, lane by lane against the latch.
module vgaw_rop_stage
    import vgaw_pkg::*;
(
    input  logic [WORD_W-1:0] value,
    input  logic [WORD_W-1:0] latch,
    input  logic [1:0]        fn,
    input  logic [LANE_W-1:0] mask8,
    input  logic              bypass,
    output logic [WORD_W-1:0] word
);
    lfun_e lf;
    assign lf = lfun_e'(fn);

    for (genvar p = 0; p < LANES; p++) begin : g_lane
        logic [LANE_W-1:0] v_l;
        logic [LANE_W-1:0] l_l;
        logic [LANE_W-1:0] op_l;
        logic [LANE_W-1:0] mrg_l;

        assign v_l = value[p*LANE_W +: LANE_W];
        assign l_l = latch[p*LANE_W +: LANE_W];

        always_comb begin
            case (lf)
                LF_AND:  op_l = v_l & l_l;
                LF_OR:   op_l = v_l | l_l;
                LF_XOR:  op_l = v_l ^ l_l;
                default: op_l = v_l;
            endcase
        end

        assign mrg_l = (op_l & mask8) | (l_l & ~mask8);
        assign word[p*LANE_W +: LANE_W] = bypass ? v_l : mrg_l;
    end
endmodule

// File: rtl/vgaw_byte_route.sv
// Byte-mode routing: word address and target plane for chain-4 / odd-even.
module vgaw_byte_route
    import vgaw_pkg::*;
#(
    parameter int WIN_AW = 16
) (
    input  logic [WIN_AW-1:0] baddr,
    input  logic              chain4,
    input  logic              page_hi,
    output logic [WIN_AW-1:0] waddr,
    output logic [LSEL_W-1:0] lane
);
    always_comb begin
        if (chain4) begin
            waddr = baddr >> LSEL_W;
            lane  = baddr[LSEL_W-1:0];
        end else begin
            waddr = baddr >> 1;
            lane  = {page_hi, baddr[0]};
        end
    end
endmodule

// File: rtl/vga_planar_writer.sv
module vga_planar_writer
    import vgaw_pkg::*;
#(
    parameter int HOST_AW = 17,
    parameter int WIN_AW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HOST_AW-1:0] wr_addr,
    input  logic [7:0]         wr_byte,
    input  logic [3:0]         plane_en,
    input  logic               chain4_en,
    input  logic               oddeven_en,
    input  logic               page_hi,
    input  logic [1:0]         wmode,
    input  logic [2:0]         rot_cnt,
    input  logic [1:0]         lfun,
    input  logic [3:0]         sr_value,
    input  logic [3:0]         sr_enable,
    input  logic [7:0]         bit_mask,
    input  logic [31:0]        latch,
    output logic               mem_we,
    output logic [WIN_AW-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    output logic [3:0]         mem_be
);
    typedef struct packed {
        logic              we;
        logic [WIN_AW-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  be;
    } port_t;

    port_t cur_q, nxt_d;

    logic              in_win;
    logic              byte_mode;
    logic [WIN_AW-1:0] win_addr;
    logic [WORD_W-1:0] mode_value;
    logic [LANE_W-1:0] mode_mask;
    logic              mode_bypass;
    logic [WORD_W-1:0] planar_word;
    logic [WIN_AW-1:0] byte_waddr;
    logic [LSEL_W-1:0] byte_lane;
    logic [LANES-1:0]  lane_oh;

    assign in_win    = (wr_addr[HOST_AW-1:WIN_AW] == '0);
    assign win_addr  = wr_addr[WIN_AW-1:0];
    assign byte_mode = chain4_en | oddeven_en;
    assign lane_oh   = LANES'(1) << byte_lane;

    vgaw_mode_stage u_mode (
        .mode   (wmode),
        .rot    (rot_cnt),
        .data   (wr_byte),
        .srv    (sr_value),
        .sre    (sr_enable),
        .gmask  (bit_mask),
        .latch  (latch),
        .value  (mode_value),
        .mask8  (mode_mask),
        .bypass (mode_bypass)
    );

    vgaw_rop_stage u_rop (
        .value  (mode_value),
        .latch  (latch),
        .fn     (lfun),
        .mask8  (mode_mask),
        .bypass (mode_bypass),
        .word   (planar_word)
    );

    vgaw_byte_route #(.WIN_AW(WIN_AW)) u_route (
        .baddr   (win_addr),
        .chain4  (chain4_en),
        .page_hi (page_hi),
        .waddr   (byte_waddr),
        .lane    (byte_lane)
    );

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.we = 1'b0;
        nxt_d.be = '0;
        if (wr_en && in_win) begin
            if (byte_mode) begin
                nxt_d.addr = byte_waddr;
                nxt_d.data = {LANES{wr_byte}};
                nxt_d.be   = lane_oh & plane_en;
            end else begin
                nxt_d.addr = win_addr;
                nxt_d.data = planar_word;
                nxt_d.be   = plane_en;
            end
            nxt_d.we = |nxt_d.be;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign mem_we    = cur_q.we;
    assign mem_addr  = cur_q.addr;
    assign mem_wdata = cur_q.data;
    assign mem_be    = cur_q.be;

    // ---------------- assertions ----------------
    assert_drop_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[HOST_AW-1:WIN_AW] != '0) |=> !mem_we);

    assert_single_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (chain4_en || oddeven_en)) |=> ($countones(mem_be) <= 1));

    assert_latch_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_win && !byte_mode && wmode == 2'd1 && plane_en != '0)
        |=> (mem_wdata == $past(latch)));

    assert_m3_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wmode == 2'd3) |-> ((mode_mask & ~bit_mask) == '0));

    assert_zero_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_win && !byte_mode && wmode != 2'd1 && bit_mask == '0 && plane_en != '0)
        |=> (mem_wdata == $past(latch)));

    assert_plane_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem_be & ~$past(plane_en)) == '0));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !mem_we);

    assert_rot_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_win && !byte_mode && wmode == 2'd0 && rot_cnt == '0 &&
         sr_enable == '0 && bit_mask == 8'hFF && lfun == 2'd0 && plane_en != '0)
        |=> (mem_wdata == {LANES{$past(wr_byte)}}));
endmodule

// File: tb/test_vga_planar_writer.sv
`timescale 1ns/1ps
module test_vga_planar_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_byte = '0;
    logic [3:0]  plane_en = '0;
    logic        chain4_en = 1'b0;
    logic        oddeven_en = 1'b0;
    logic        page_hi = 1'b0;
    logic [1:0]  wmode = '0;
    logic [2:0]  rot_cnt = '0;
    logic [1:0]  lfun = '0;
    logic [3:0]  sr_value = '0;
    logic [3:0]  sr_enable = '0;
    logic [7:0]  bit_mask = '0;
    logic [31:0] latch = '0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vga_planar_writer i_vga_planar_writer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_byte(wr_byte), .plane_en(plane_en), .chain4_en(chain4_en),
        .oddeven_en(oddeven_en), .page_hi(page_hi), .wmode(wmode),
        .rot_cnt(rot_cnt), .lfun(lfun), .sr_value(sr_value),
        .sr_enable(sr_enable), .bit_mask(bit_mask), .latch(latch),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  md;
        logic [2:0]  rot;
        logic [1:0]  fn;
        logic [3:0]  srv;
        logic [3:0]  sre;
        logic [7:0]  bm;
        logic [3:0]  pe;
        logic [7:0]  d;
        logic [31:0] lat;
        logic [15:0] a;
        logic        ew;
        logic [31:0] ed;
        logic [3:0]  eb;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{4'd12,2'd0,3'd0,2'd0,4'h0,4'h0,8'hFF,4'hF,8'hA5,32'h00000000,16'h0000,1'b1,32'hA5A5A5A5,4'hF}, // R12 rot 0
        '{4'd4, 2'd0,3'd1,2'd0,4'h0,4'h0,8'hFF,4'hF,8'h81,32'h00000000,16'h0001,1'b1,32'hC0C0C0C0,4'hF}, // R4 rotate 1
        '{4'd12,2'd0,3'd7,2'd0,4'h0,4'h0,8'hFF,4'hF,8'h01,32'h00000000,16'h0002,1'b1,32'h02020202,4'hF}, // R12 rot 7
        '{4'd4, 2'd0,3'd0,2'd0,4'h5,4'h3,8'hFF,4'hF,8'h3C,32'h00000000,16'h0003,1'b1,32'h3C3C00FF,4'hF}, // R4 set/reset
        '{4'd9, 2'd0,3'd0,2'd0,4'h0,4'h0,8'h0F,4'hF,8'hFF,32'h12345678,16'h0004,1'b1,32'h1F3F5F7F,4'hF}, // R9 merge
        '{4'd5, 2'd1,3'd0,2'd3,4'h0,4'h0,8'h00,4'hF,8'h00,32'hDEADBEEF,16'h0005,1'b1,32'hDEADBEEF,4'hF}, // R5 latch copy
        '{4'd6, 2'd2,3'd0,2'd0,4'h0,4'h0,8'hF0,4'hF,8'h0A,32'h11111111,16'h0006,1'b1,32'hF101F101,4'hF}, // R6 expand
        '{4'd7, 2'd3,3'd4,2'd0,4'h6,4'h0,8'hCC,4'hF,8'h0F,32'h00000000,16'h0007,1'b1,32'h00C0C000,4'hF}, // R7 masked
        '{4'd8, 2'd0,3'd0,2'd1,4'h0,4'h0,8'hFF,4'hF,8'hF0,32'h3C3C3C3C,16'h0008,1'b1,32'h30303030,4'hF}, // R8 and
        '{4'd8, 2'd0,3'd0,2'd2,4'h0,4'h0,8'hFF,4'hF,8'hF0,32'h01020304,16'h0009,1'b1,32'hF1F2F3F4,4'hF}, // R8 or
        '{4'd8, 2'd0,3'd0,2'd3,4'h0,4'h0,8'hFF,4'hF,8'hFF,32'h0F00F055,16'h000A,1'b1,32'hF0FF0FAA,4'hF}, // R8 xor
        '{4'd10,2'd0,3'd0,2'd0,4'h0,4'h0,8'hFF,4'h5,8'h55,32'h00000000,16'h000B,1'b1,32'h55555555,4'h5}, // R10 partial
        '{4'd10,2'd0,3'd0,2'd0,4'h0,4'h0,8'hFF,4'h0,8'h55,32'h00000000,16'h000C,1'b0,32'h00000000,4'h0}, // R10 none
        '{4'd5, 2'd1,3'd0,2'd0,4'h0,4'h0,8'hFF,4'hA,8'h00,32'h11223344,16'h000D,1'b1,32'h11223344,4'hA}, // R5 with enables
        '{4'd1, 2'd0,3'd0,2'd0,4'h0,4'h0,8'hFF,4'hF,8'h77,32'h00000000,16'hFFFF,1'b1,32'h77777777,4'hF}  // R1 last address
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // strobe one write; outputs are compared on the following falling edge
    task automatic pulse();
        @(negedge clk);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset we", {31'd0, mem_we}, 32'd0);
        chk("R11 reset be", {28'd0, mem_be}, 32'd0);
        chk("R11 reset data", mem_wdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk, planar modes
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[i].rq, i);
            wmode = TBL[i].md; rot_cnt = TBL[i].rot; lfun = TBL[i].fn;
            sr_value = TBL[i].srv; sr_enable = TBL[i].sre; bit_mask = TBL[i].bm;
            plane_en = TBL[i].pe; wr_byte = TBL[i].d; latch = TBL[i].lat;
            wr_addr = {1'b0, TBL[i].a};
            pulse();
            chk({tag, " we"}, {31'd0, mem_we}, {31'd0, TBL[i].ew});
            chk({tag, " be"}, {28'd0, mem_be}, {28'd0, TBL[i].eb});
            if (TBL[i].ew) begin
                chk({tag, " data"}, mem_wdata, TBL[i].ed);
                chk({tag, " addr"}, {16'd0, mem_addr}, {16'd0, TBL[i].a});
            end
        end

        // R11: idle cycle after a write
        @(negedge clk);
        chk("R11 idle we", {31'd0, mem_we}, 32'd0);

        // R1: out-of-window addresses dropped
        wmode = 2'd0; rot_cnt = '0; lfun = '0; sr_enable = '0; bit_mask = 8'hFF;
        plane_en = 4'hF; wr_byte = 8'h3E;
        wr_addr = 17'h10000; pulse();
        chk("R1 0x10000 we", {31'd0, mem_we}, 32'd0);
        wr_addr = 17'h1FFFF; pulse();
        chk("R1 0x1FFFF we", {31'd0, mem_we}, 32'd0);

        // R2: chain-4 byte writes
        chain4_en = 1'b1; wr_byte = 8'h9A; wr_addr = 17'h00006; pulse();
        chk("R2 chain4 we", {31'd0, mem_we}, 32'd1);
        chk("R2 chain4 be", {28'd0, mem_be}, 32'h4);
        chk("R2 chain4 addr", {16'd0, mem_addr}, 32'h0001);
        chk("R2 chain4 data", mem_wdata, 32'h9A9A9A9A);
        plane_en = 4'b1011; pulse();
        chk("R2 chain4 gated we", {31'd0, mem_we}, 32'd0);
        plane_en = 4'hF; wr_addr = 17'h10004; pulse();
        chk("R1 chain4 high we", {31'd0, mem_we}, 32'd0);
        oddeven_en = 1'b1; page_hi = 1'b1; wr_addr = 17'h00001; pulse();
        chk("R2 priority be", {28'd0, mem_be}, 32'h2);
        chk("R2 priority addr", {16'd0, mem_addr}, 32'h0000);

        // R3: odd/even byte writes
        chain4_en = 1'b0; page_hi = 1'b1; wr_byte = 8'h6B; wr_addr = 17'h00013; pulse();
        chk("R3 oe page1 be", {28'd0, mem_be}, 32'h8);
        chk("R3 oe page1 addr", {16'd0, mem_addr}, 32'h0009);
        chk("R3 oe data", mem_wdata, 32'h6B6B6B6B);
        page_hi = 1'b0; wr_addr = 17'h00012; pulse();
        chk("R3 oe page0 be", {28'd0, mem_be}, 32'h1);
        chk("R3 oe page0 addr", {16'd0, mem_addr}, 32'h0009);
        plane_en = 4'b1110; pulse();
        chk("R3 oe gated we", {31'd0, mem_we}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule